// File: doc/BRIEF.md
# Encoder Angle Linearisation Corrector

This block takes an unsigned rotor angle sample and removes the systematic error of the encoder. A full turn maps to the whole word range. The error is stored as a table of 64 signed correction values, spread evenly over one revolution.

The upper angle bits pick a table segment, and the remaining bits pick a point inside that segment. The block interpolates linearly between the two ends of the segment and adds the resulting bias to the angle. The corrected angle is returned one clock later and wraps modulo a full turn. The segment after the last entry wraps back to the first.

The table is loaded through a single-word write port. Correction is applied only while at least one table value is non-zero. With an all-zero table, every sample leaves the block unchanged.

Top module: `enc_lin_corrector`

## Requirements
- R1: The table has 64 entries, each a signed 16-bit value in units of one angle LSB. A write with `wr_en_i` high stores `wr_data_i` into the entry given by `wr_addr_i` at that clock edge.
- R2: Reset does four things. It clears every table entry to zero, drives `out_valid_o` low, drives `out_angle_o` to zero, and leaves correction inactive.
- R3: While every table entry is zero, a sample is returned with `out_angle_o` equal to the input angle.
- R4: The correction-active state is re-evaluated on every table write. Writing a non-zero value turns correction on. Writing zeros back into all non-zero entries turns it off again.
- R5: For a 16-bit angle, bits [15:10] form the segment index i. Bits [9:0] form an unsigned interpolation weight f.
- R6: The bias equals c[i] + floor((c[i+1] − c[i]) · f / 1024). It always lies between c[i] and c[i+1].
- R7: The neighbour of entry 63 is entry 0, so the last segment interpolates towards entry 0.
- R8: The output is (angle + bias) mod 65536. It wraps past the top of the range when the bias is positive and below zero when the bias is negative.
- R9: `out_valid_o` follows `in_valid_i` one clock later. `out_angle_o` changes only after a cycle with `in_valid_i` high and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 6 | Table entry index for the write |
| wr_data_i | input | 16 | Signed correction value to store |
| in_valid_i | input | 1 | Input angle sample is valid |
| in_angle_i | input | 16 | Unsigned input angle, full word is one turn |
| out_valid_o | output | 1 | Corrected sample is valid |
| out_angle_o | output | 16 | Corrected angle, modulo one turn |

## Verification
Each kind of internal fault shows at the ports one clock after the affected sample is taken:

- **Corrupted table entry:** the corrected angle is wrong only for angles inside the two segments that touch that entry. The vectors therefore probe the start, the middle and the end of several segments, including the segment that wraps from entry 63 to entry 0.
- **Stale correction-active state:** a non-zero bias appears on samples that should pass through unchanged, or the bias vanishes when it should be applied. This is checked just after the table is cleared back to zeros and just after a single entry is set.
- **Wrong rounding or wrong overflow width in the interpolation:** this moves the result by one LSB or more. It is exposed by the weights 1 and 1023 and by a segment spanning the full signed range.

// File: rtl/enc_lin_pkg.sv
package enc_lin_pkg;
  localparam int unsigned ANGLE_W_DEF = 16;
  localparam int unsigned IDX_W_DEF   = 6;
  localparam int unsigned COEF_W_DEF  = 16;
endpackage

// File: rtl/enc_lin_table.sv
module enc_lin_table #(
  parameter int unsigned IDX_W  = enc_lin_pkg::IDX_W_DEF,
  parameter int unsigned COEF_W = enc_lin_pkg::COEF_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_addr_i,
  input  logic signed [COEF_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic signed [COEF_W-1:0] rd_lo_o,
  output logic signed [COEF_W-1:0] rd_hi_o,
  output logic                     active_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  logic signed [COEF_W-1:0] tbl_q [ENTRIES];
  logic [ENTRIES-1:0]       nz_next;
  logic                     active_q;
  logic [IDX_W-1:0]         idx_hi;

  // non-zero map of the table as it will be after this cycle's write
  for (genvar g = 0; g < ENTRIES; g++) begin : g_nz
    assign nz_next[g] = (wr_en_i && (wr_addr_i == IDX_W'(g))) ? (wr_data_i != '0)
                                                               : (tbl_q[g] != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ENTRIES; k++) tbl_q[k] <= '0;
      active_q <= 1'b0;
    end else if (wr_en_i) begin
      tbl_q[wr_addr_i] <= wr_data_i;
      active_q         <= |nz_next;
    end
  end

  // modulo-ENTRIES neighbour: last segment wraps to entry 0
  assign idx_hi   = rd_idx_i + IDX_W'(1);
  assign rd_lo_o  = tbl_q[rd_idx_i];
  assign rd_hi_o  = tbl_q[idx_hi];
  assign active_o = active_q;

  assert_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (tbl_q[$past(wr_addr_i)] == $past(wr_data_i)));

  assert_active_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i != '0)) |=> active_o);
endmodule

// File: rtl/enc_lin_interp.sv
module enc_lin_interp #(
  parameter int unsigned COEF_W = enc_lin_pkg::COEF_W_DEF,
  parameter int unsigned FRAC_W = 10
) (
  input  logic signed [COEF_W-1:0] c_lo_i,
  input  logic signed [COEF_W-1:0] c_hi_i,
  input  logic [FRAC_W-1:0]        frac_i,
  output logic signed [COEF_W-1:0] bias_o
);
  localparam int unsigned PW = COEF_W + FRAC_W + 2;

  logic signed [COEF_W:0]   diff;
  logic signed [FRAC_W:0]   frac_s;
  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     step;
  logic signed [PW-1:0]     sum;

  assign diff   = {c_hi_i[COEF_W-1], c_hi_i} - {c_lo_i[COEF_W-1], c_lo_i};
  assign frac_s = {1'b0, frac_i};
  assign prod   = PW'(diff) * PW'(frac_s);
  assign step   = prod >>> FRAC_W;  // floor division
  assign sum    = step + PW'(c_lo_i);
  // result lies between the two entries, so it fits COEF_W
  assign bias_o = COEF_W'(sum);
endmodule

// File: rtl/enc_lin_corrector.sv
module enc_lin_corrector #(
  parameter int unsigned ANGLE_W = enc_lin_pkg::ANGLE_W_DEF,
  parameter int unsigned IDX_W   = enc_lin_pkg::IDX_W_DEF,
  parameter int unsigned COEF_W  = enc_lin_pkg::COEF_W_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_addr_i,
  input  logic [COEF_W-1:0]  wr_data_i,
  input  logic               in_valid_i,
  input  logic [ANGLE_W-1:0] in_angle_i,
  output logic               out_valid_o,
  output logic [ANGLE_W-1:0] out_angle_o
);
  localparam int unsigned FRAC_W = ANGLE_W - IDX_W;

  logic [IDX_W-1:0]         seg_idx;
  logic [FRAC_W-1:0]        seg_frac;
  logic signed [COEF_W-1:0] c_lo, c_hi, bias;
  logic                     lin_active;
  logic [ANGLE_W-1:0]       corr_angle;
  logic                     out_valid_q;
  logic [ANGLE_W-1:0]       out_angle_q;

  assign seg_idx  = in_angle_i[ANGLE_W-1 -: IDX_W];
  assign seg_frac = in_angle_i[FRAC_W-1:0];

  enc_lin_table #(.IDX_W(IDX_W), .COEF_W(COEF_W)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .rd_idx_i (seg_idx),
    .rd_lo_o  (c_lo),
    .rd_hi_o  (c_hi),
    .active_o (lin_active)
  );

  enc_lin_interp #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_interp (
    .c_lo_i(c_lo),
    .c_hi_i(c_hi),
    .frac_i(seg_frac),
    .bias_o(bias)
  );

  // modulo-turn add, bias sign-extended to angle width
  assign corr_angle = lin_active ? (in_angle_i + ANGLE_W'(bias)) : in_angle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_angle_q <= '0;
    end else begin
      out_valid_q <= in_valid_i;
      if (in_valid_i) out_angle_q <= corr_angle;
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_angle_o = out_angle_q;

  assert_valid_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  assert_valid_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_angle_o));

  assert_passthrough_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !lin_active) |=> (out_angle_o == $past(in_angle_i)));

  assert_bias_bounds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> (((bias >= c_lo) || (bias >= c_hi)) && ((bias <= c_lo) || (bias <= c_hi))));
endmodule

// File: tb/tb_enc_lin_corrector.sv
module tb_enc_lin_corrector;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [5:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        in_valid_i = 1'b0;
  logic [15:0] in_angle_i = '0;
  logic        out_valid_o;
  logic [15:0] out_angle_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk_i = ~clk_i;

  enc_lin_corrector dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .in_valid_i(in_valid_i), .in_angle_i(in_angle_i),
    .out_valid_o(out_valid_o), .out_angle_o(out_angle_o)
  );

  // {angle, expected}; table: c0=100 c1=-100 c2=-2000 c3=-5000 c5=c6=1000
  // c10=-32768 c11=32767 c63=-300, others zero
  localparam logic [31:0] VEC [13] = '{
    {16'h0000, 16'h0064},  // R5 frac 0
    {16'h0001, 16'h0064},  // R6 floor of -200/1024
    {16'h0100, 16'h0132},  // R6 quarter
    {16'h0200, 16'h0200},  // R6 midpoint
    {16'h0400, 16'h039C},  // R5 segment 1
    {16'h0800, 16'h0030},  // R8 no wrap
    {16'h0C00, 16'hF878},  // R8 wrap below zero
    {16'hFC00, 16'hFAD4},  // R7 entry 63
    {16'hFE00, 16'hFD9C},  // R7 towards entry 0
    {16'hFFFF, 16'h0062},  // R7 R8 wrap past top
    {16'h1655, 16'h1A3D},  // R6 flat segment
    {16'h2800, 16'hA800},  // R6 negative extreme
    {16'h2BFF, 16'hABBE}   // R6 full-range slope
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_entry(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic sample(input logic [15:0] a, output logic [15:0] res, output logic v);
    @(negedge clk_i);
    in_valid_i = 1'b1; in_angle_i = a;
    @(posedge clk_i);
    #1;
    res = out_angle_o; v = out_valid_o;
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] r, held;
    logic v;
    #9;
    check({15'd0, out_valid_o}, 16'd0, "R2 valid in reset");
    check(out_angle_o, 16'h0000, "R2 angle in reset");
    @(negedge clk_i); rst_ni = 1'b1;

    sample(16'h2BFF, r, v);
    check({15'd0, v}, 16'd1, "R9 valid after sample");
    check(r, 16'h2BFF, "R3 empty table passthrough");

    write_entry(6'd0,  16'd100);
    write_entry(6'd1,  -16'sd100);
    write_entry(6'd2,  -16'sd2000);
    write_entry(6'd3,  -16'sd5000);
    write_entry(6'd5,  16'd1000);
    write_entry(6'd6,  16'd1000);
    write_entry(6'd10, 16'h8000);
    write_entry(6'd11, 16'h7FFF);
    write_entry(6'd63, -16'sd300);

    for (int i = 0; i < 13; i++) begin
      sample(VEC[i][31:16], r, v);
      check(r, VEC[i][15:0], $sformatf("R1 R5 R6 R7 R8 vector %0d", i));
    end

    // R9: idle cycle holds output
    held = out_angle_o;
    @(negedge clk_i);
    in_angle_i = 16'h1234;
    @(posedge clk_i); #1;
    check({15'd0, out_valid_o}, 16'd0, "R9 valid low when idle");
    check(out_angle_o, held, "R9 angle held when idle");

    // R4: clearing all entries deactivates correction
    write_entry(6'd0, 16'd0);  write_entry(6'd1, 16'd0);
    write_entry(6'd2, 16'd0);  write_entry(6'd3, 16'd0);
    write_entry(6'd5, 16'd0);  write_entry(6'd6, 16'd0);
    write_entry(6'd10, 16'd0); write_entry(6'd11, 16'd0);
    write_entry(6'd63, 16'd0);
    sample(16'h2BFF, r, v);
    check(r, 16'h2BFF, "R4 cleared table passthrough");

    write_entry(6'd20, 16'd7);
    sample(16'h5000, r, v);
    check(r, 16'h5007, "R4 single entry reactivates");

    // R2: reset mid-run clears table and output
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check({15'd0, out_valid_o}, 16'd0, "R2 valid after reset");
    check(out_angle_o, 16'h0000, "R2 angle after reset");
    @(negedge clk_i); rst_ni = 1'b1;
    sample(16'h5000, r, v);
    check(r, 16'h5000, "R2 table cleared by reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule